// File: doc/BRIEF.md
# Program Trace Capture Buffer

This block records a processor's program-flow trace into on-chip memory. Each cycle it samples a 3-bit instruction-flow status code, a 2-bit flow-queue status code and a 32-bit bus address that carries a program-trace cycle qualifier. The status code 3'b011 is the sync report. It marks both the opening and the closing of a capture window, and it is never written to memory.

The unit has two modes, selected by `mode` at reset or clear. In back-trace mode (mode 0) it stores from the first cycle after reset into a circular buffer. The first sync report is the assertion of sync and capture continues through it. The second sync report ends capture, so the memory then holds the most recent flow before the event. In window mode (mode 1) nothing is stored until a sync report arrives. The next sync report ends capture. When the buffer fills in window mode, further entries are dropped and a sticky overflow flag is raised.

Once capture ends, the buffer freezes and `done` goes high. A host reads entries by logical index, where index 0 is the oldest. The read data is registered, so it appears one cycle after the index is presented. A synchronous clear re-arms the unit.

Top module: `trace_capture`

## Requirements
- R1: After reset or a cycle with `clr` high, `done`, `overflow` and `entry_count` are all zero.
- R2: The status code 3'b011 on `vf` is recognised as a sync report, and a sync cycle never produces a stored entry.
- R3: With `mode`=0 at reset or clear, every qualifying cycle is stored from the first clock after reset or clear, with no trigger needed.
- R4: In back-trace mode, the first sync report does not stop capture. The second sync report ends it, and `done` is high from the following cycle.
- R5: With `mode`=1, cycles before the first sync report are not stored. Storing starts on the cycle after that report, and the next sync report ends capture with `done` high.
- R6: In back-trace mode the buffer wraps and keeps the last DEPTH entries. `entry_count` saturates at DEPTH and `overflow` stays 0.
- R7: In window mode, entries beyond DEPTH are dropped, the first DEPTH entries are kept, and `overflow` is set and stays set until clear.
- R8: A stored entry is 38 bits: [37:35] vf, [34:33] vfls, [32] address-valid (the `addr_qual` value), [31:0] the address when qualified and zero otherwise.
- R9: An idle cycle (`vf`=000, `vfls`=00, `addr_qual`=0) is not stored.
- R10: While `done` is high, the inputs have no effect: `entry_count` and the buffer contents stay frozen until clear.
- R11: `rd_data` returns the entry at logical index `rd_idx`, where 0 is the oldest stored entry. The data appears one clock after `rd_idx` is sampled.
- R12: Asserting `clr` during capture discards the capture and re-arms the unit in the mode present on `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous re-arm: clears pointers, counts and flags |
| mode | input | 1 | 0 = back-trace, 1 = window; sampled at reset or clear |
| vf | input | 3 | Instruction-flow status; 3'b011 is the sync report |
| vfls | input | 2 | Flow-queue status |
| addr_qual | input | 1 | Bus cycle carries the program-trace attribute |
| addr | input | 32 | Bus address |
| rd_idx | input | log2(DEPTH) | Logical read index, 0 = oldest |
| rd_data | output | 38 | Registered entry at `rd_idx` |
| entry_count | output | log2(DEPTH)+1 | Number of valid entries |
| done | output | 1 | Capture finished, buffer frozen |
| overflow | output | 1 | Window mode dropped an entry |

## Verification
The bench drives back-trace runs long enough to wrap the buffer several times. A design that used the raw write pointer as the read origin would return entries in rotated order, and one that kept counting past DEPTH would report the wrong count. In window mode it puts activity before the first sync report and after the closing one; a design that stored either would show extra entries. It also fills a window beyond DEPTH, which catches designs that overwrite instead of dropping or that miss the overflow flag. Other runs include unqualified cycles with nonzero addresses, idle cycles, and a clear in the middle of a capture. These expose a leaked address field, stored idle words, or stale state surviving a re-arm.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;
  localparam logic [2:0] VF_SYNC = 3'b011;
  localparam int ADDR_W  = 32;
  localparam int ENTRY_W = 3 + 2 + 1 + ADDR_W;

  typedef enum logic [1:0] {ST_ARMED, ST_CAPTURE, ST_DONE} cap_state_t;
  typedef enum logic {MODE_BACK = 1'b0, MODE_WINDOW = 1'b1} cap_mode_t;

  typedef struct packed {
    logic [2:0]        vf;
    logic [1:0]        vfls;
    logic              addr_ok;
    logic [ADDR_W-1:0] addr;
  } trace_entry_t;
endpackage

// File: rtl/trace_cap_ctrl.sv
module trace_cap_ctrl
  import trace_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      mode,
  input  logic [2:0] vf,
  input  logic [1:0] vfls,
  input  logic      addr_qual,
  output cap_mode_t cur_mode,
  output logic      store,
  output logic      done
);
  cap_state_t state;
  logic       half_seen;
  logic       is_sync;
  logic       active;

  assign is_sync = (vf == VF_SYNC);
  assign active  = (vf != 3'b000) || (vfls != 2'b00) || addr_qual;
  assign store   = (state == ST_CAPTURE) && !is_sync && active && !clr && !rst;
  assign done    = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_mode  <= cap_mode_t'(mode);
      state     <= mode ? ST_ARMED : ST_CAPTURE;
      half_seen <= 1'b0;
    end else begin
      case (state)
        ST_ARMED:   if (is_sync) state <= ST_CAPTURE;
        ST_CAPTURE: if (is_sync) begin
          if (cur_mode == MODE_WINDOW || half_seen) state <= ST_DONE;
          else half_seen <= 1'b1;
        end
        ST_DONE:    state <= ST_DONE;
        default:    state <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/trace_cap_ptr.sv
module trace_cap_ptr
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          store,
  input  cap_mode_t     cur_mode,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_base,
  output logic [CW-1:0] entry_count,
  output logic          overflow
);
  logic full;
  logic window;

  assign full    = (entry_count == CW'(DEPTH));
  assign window  = (cur_mode == MODE_WINDOW);
  assign wr_en   = store && !(window && full);
  // Window mode stops at DEPTH writes, leaving the pointer back at zero,
  // so one rule gives the oldest slot in both modes.
  assign rd_base = full ? wr_addr : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_addr     <= '0;
      entry_count <= '0;
      overflow    <= 1'b0;
    end else if (store) begin
      if (window && full) begin
        overflow <= 1'b1;
      end else begin
        wr_addr <= wr_addr + 1'b1;
        if (!full) entry_count <= entry_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_cap_mem.sv
module trace_cap_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 38,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= ram[rd_addr];
  end
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               mode,
  input  logic [2:0]         vf,
  input  logic [1:0]         vfls,
  input  logic               addr_qual,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [AW-1:0]      rd_idx,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [CW-1:0]      entry_count,
  output logic               done,
  output logic               overflow
);
  cap_mode_t    cur_mode;
  logic         store;
  logic         wr_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_base;
  logic [AW-1:0] rd_addr;
  trace_entry_t new_entry;

  trace_cap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .mode(mode),
    .vf(vf), .vfls(vfls), .addr_qual(addr_qual),
    .cur_mode(cur_mode), .store(store), .done(done)
  );

  trace_cap_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .clr(clr), .store(store), .cur_mode(cur_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_base(rd_base),
    .entry_count(entry_count), .overflow(overflow)
  );

  always_comb begin
    new_entry.vf      = vf;
    new_entry.vfls    = vfls;
    new_entry.addr_ok = addr_qual;
    new_entry.addr    = addr_qual ? addr : '0;
  end

  assign rd_addr = rd_base + rd_idx;

  trace_cap_mem #(.DEPTH(DEPTH), .W(ENTRY_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(new_entry),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk
  import trace_cap_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1
)(
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic [2:0]    vf,
  input logic [1:0]    vfls,
  input logic          addr_qual,
  input logic [CW-1:0] entry_count,
  input logic          done,
  input logic          overflow,
  input cap_mode_t     cur_mode
);
  a_r1_clear_state: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!done && entry_count == '0 && !overflow));

  a_r2_sync_not_stored: assert property (@(posedge clk) disable iff (rst)
    (!clr && vf == VF_SYNC) |=> $stable(entry_count));

  a_r9_idle_not_stored: assert property (@(posedge clk) disable iff (rst)
    (!clr && vf == 3'b000 && vfls == 2'b00 && !addr_qual) |=> $stable(entry_count));

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> (done && $stable(entry_count) && $stable(overflow)));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr) |=> overflow);

  a_r6_back_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_BACK) |-> !overflow);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    entry_count <= CW'(DEPTH));

  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (entry_count == $past(entry_count) ||
              entry_count == CW'($past(entry_count) + 1'b1)));
endmodule

bind trace_capture trace_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .vf(vf), .vfls(vfls),
  .addr_qual(addr_qual), .entry_count(entry_count), .done(done),
  .overflow(overflow), .cur_mode(cur_mode)
);

// File: tb/tb_trace_capture.sv
module tb_trace_capture;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, mode = 1'b0;
  logic [2:0] vf = '0;
  logic [1:0] vfls = '0;
  logic addr_qual = 1'b0;
  logic [31:0] addr = '0;
  logic [AW-1:0] rd_idx = '0;
  logic [37:0] rd_data;
  logic [CW-1:0] entry_count;
  logic done, overflow;

  always #4 clk = ~clk;

  trace_capture #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .clr(clr), .mode(mode), .vf(vf), .vfls(vfls),
    .addr_qual(addr_qual), .addr(addr), .rd_idx(rd_idx), .rd_data(rd_data),
    .entry_count(entry_count), .done(done), .overflow(overflow)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // requirement model: 0 armed, 1 capture, 2 done
  logic [37:0] exp_q[$];
  int  m_st;
  bit  m_half, m_ovf, m_mode;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void rearm(input bit m);
    exp_q.delete();
    m_mode = m; m_st = m ? 0 : 1; m_half = 0; m_ovf = 0;
  endfunction

  task automatic step(input logic [2:0] v, input logic [1:0] s, input bit q,
                      input logic [31:0] a, input bit c);
    vf = v; vfls = s; addr_qual = q; addr = a; clr = c;
    @(posedge clk);
    if (c) rearm(mode);
    else begin
      if (m_st == 1 && v != 3'b011 && (v != 0 || s != 0 || q)) begin
        logic [37:0] e;
        e = {v, s, q, q ? a : 32'h0};
        if (!m_mode) begin
          exp_q.push_back(e);
          if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
        end else if (exp_q.size() < DEPTH) exp_q.push_back(e);
        else m_ovf = 1;
      end
      if (v == 3'b011) begin
        if (m_st == 0) m_st = 1;
        else if (m_st == 1) begin
          if (m_mode || m_half) m_st = 2; else m_half = 1;
        end
      end
    end
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic rstep();
    logic [2:0] v;
    v = 3'($urandom % 8);
    if (v == 3'b011) v = 3'b101;
    if ($urandom % 6 == 0) step(3'b000, 2'b00, 1'b0, $urandom, 1'b0);
    else step(v, 2'($urandom % 4), 1'($urandom % 2), $urandom, 1'b0);
  endtask

  task automatic sync_step();
    step(3'b011, 2'($urandom % 4), 1'($urandom % 2), $urandom, 1'b0);
  endtask

  task automatic do_reset(input bit m);
    mode = m; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rearm(m);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " count"}, 64'(entry_count), 64'(exp_q.size()));
    chk({tag, " done"}, 64'(done), 64'(m_st == 2));
    chk({tag, " overflow"}, 64'(overflow), 64'(m_ovf));
    for (int i = 0; i < exp_q.size(); i++) begin
      rd_idx = AW'(i);
      step(3'b000, 2'b00, 1'b0, 32'h0, 1'b0);
      chk({tag, " R11 R8 entry"}, 64'(rd_data), 64'(exp_q[i]));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset(1'b0);
    chk("R1 reset done", 64'(done), 0);
    chk("R1 reset count", 64'(entry_count), 0);
    chk("R1 reset overflow", 64'(overflow), 0);

    // short back-trace run with directed address-valid cases
    step(3'b001, 2'b10, 1'b0, 32'hDEAD_BEEF, 1'b0);   // R8 address masked
    step(3'b000, 2'b00, 1'b1, 32'h1234_5678, 1'b0);   // R8 qualified address
    step(3'b000, 2'b00, 1'b0, 32'hFFFF_FFFF, 1'b0);   // R9 idle
    chk("R3 R9 early count", 64'(entry_count), 2);
    repeat (4) rstep();
    sync_step();
    chk("R4 first sync keeps capturing", 64'(done), 0);
    repeat (5) rstep();
    sync_step();
    chk("R4 second sync ends", 64'(done), 1);
    repeat (3) step(3'b110, 2'b01, 1'b1, 32'hABCD_0000, 1'b0);
    chk("R10 frozen count", 64'(entry_count), 64'(exp_q.size()));
    check_all("R3 R4 R2 short back-trace");

    // long back-trace run that wraps several times
    step(3'b000, 2'b00, 1'b0, 32'h0, 1'b1);
    chk("R12 clr count", 64'(entry_count), 0);
    chk("R12 clr done", 64'(done), 0);
    repeat (40) rstep();
    sync_step();
    repeat (10) rstep();
    sync_step();
    check_all("R6 R9 wrapped back-trace");

    // window mode with activity outside the window
    do_reset(1'b1);
    repeat (5) step(3'b100, 2'b11, 1'b1, 32'h5555_0000, 1'b0);
    chk("R5 pre-sync not stored", 64'(entry_count), 0);
    sync_step();
    repeat (9) rstep();
    sync_step();
    chk("R5 window done", 64'(done), 1);
    repeat (4) step(3'b111, 2'b01, 1'b1, 32'h7777_0000, 1'b0);
    check_all("R5 R10 window");

    // window overflow
    mode = 1'b1;
    step(3'b000, 2'b00, 1'b0, 32'h0, 1'b1);
    sync_step();
    repeat (DEPTH + 6) step(3'($urandom % 3), 2'b01, 1'b1, $urandom, 1'b0);
    sync_step();
    check_all("R7 window overflow");

    // clear in the middle of a back-trace capture
    mode = 1'b0;
    step(3'b000, 2'b00, 1'b0, 32'h0, 1'b1);
    repeat (5) rstep();
    sync_step();
    step(3'b000, 2'b00, 1'b0, 32'h0, 1'b1);
    chk("R1 R12 mid clear count", 64'(entry_count), 0);
    chk("R12 mid clear done", 64'(done), 0);
    repeat (3) rstep();
    sync_step();
    chk("R12 half sync forgotten", 64'(done), 0);
    repeat (2) rstep();
    sync_step();
    check_all("R12 R2 re-armed back-trace");

    finished = 1;
    summary();
    $finish;
  end
endmodule